// File: doc/BRIEF.md
# Test-Port Instruction Register and Decoder

This block holds the instruction path that sits behind a four-wire test access port state machine. The state machine tells it when to capture, shift and update, and the block supplies the serial instruction stage, the shadow latch that holds the current instruction, and the decoder that turns the current instruction into data-register selects and test-mode outputs. While the state machine walks the data column, the block also routes the serial output of the selected data register onto the test data output.

Two small data registers live inside the block: the 1-bit bypass stage and a 32-bit shift register that loads either the device identification word or the user code word. Boundary-scan cells and the four user-defined data registers are outside. The block only selects them and takes their serial outputs back in. A mode output floats the general-purpose user pins while leaving the test port itself working. A second mode output hands the pins to the boundary-scan cells. Any instruction the decoder does not recognise, including the internal-test code, falls back to bypass.

Top module: `tap_instr_unit`

## Requirements
- R1: On a rising `tck` edge with `capture_ir` high, the instruction stage loads `CAP_PAT` (default 6'b110001, whose two low bits are 01). During `shift_ir` that pattern appears on `tdo` least significant bit first, one bit per rising edge.
- R2: With `shift_ir` high, each rising `tck` edge moves `tdi` into the top bit of the instruction stage. After `IR_W` edges the stage holds the word sent, least significant bit first.
- R3: `ir_code` changes only on the falling `tck` edge of a cycle in which `update_ir` (or `tlr_st`) is high. In an `update_ir` cycle, before that falling edge, it still shows the previous instruction.
- R4: `trst_n` low, or `tlr_st` high at a falling `tck` edge, sets `ir_code` to the IDCODE code 6'h09 when `HAS_ID=1`, and to the all-ones bypass code otherwise.
- R5: Decode table (6-bit codes): 6'h00 selects boundary scan with `extest_mode` high; 6'h01 selects boundary scan only; 6'h09 selects the identification word; 6'h08 selects the user code word; 6'h02, 6'h03, 6'h22 and 6'h23 select `sel_user` bits 0, 1, 2 and 3; 6'h0A selects bypass with `hiz_user_io` high.
- R6: Every other code, including 6'h3F and the internal-test code 6'h07, selects bypass. The bypass stage captures 0 in Capture-DR and then delays `tdi` to `tdo` by one shift.
- R7: When the identification word or the user code word is selected, Capture-DR loads `ID_VAL` (default 32'h1A3C5E97) or `UC_VAL` (default 32'h5A5A0F0F). Shift-DR sends those 32 bits least significant bit first, followed by the `tdi` bits sent 32 shifts earlier.
- R8: A Capture-DR cycle loads only the data register that the current instruction selects. Internal data registers that are not selected keep their contents.
- R9: `hiz_user_io` is high only for code 6'h0A and `extest_mode` only for 6'h00. The two are never high together.
- R10: While `tlr_st` is high, `extest_mode` and `hiz_user_io` are low in the same cycle. A `tlr_st` that coincides with `update_ir` wins over the update.
- R11: `tdo` equals instruction-stage bit 0 while `shift_ir` is high. Otherwise it is the serial output of the selected data register: `bsr_so` for boundary scan, and `user_so[i]` when `sel_user[i]` is high.
- R12: Exactly one of `sel_bypass`, `sel_idcode`, `sel_usercode`, `sel_bsr` and the `sel_user` bits is high at any time after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr_st | input | 1 | State machine is in Test-Logic-Reset |
| capture_ir | input | 1 | Capture-IR state |
| shift_ir | input | 1 | Shift-IR state |
| update_ir | input | 1 | Update-IR state |
| capture_dr | input | 1 | Capture-DR state |
| shift_dr | input | 1 | Shift-DR state |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the boundary-scan chain |
| user_so | input | 4 | Serial outputs of the four user data registers |
| tdo | output | 1 | Serial test data out (unregistered) |
| ir_code | output | IR_W | Current instruction |
| sel_bypass | output | 1 | Bypass register selected |
| sel_idcode | output | 1 | Identification word selected |
| sel_usercode | output | 1 | User code word selected |
| sel_bsr | output | 1 | Boundary-scan chain selected |
| sel_user | output | 4 | One-hot select of the user data registers |
| extest_mode | output | 1 | Boundary cells drive the pins |
| hiz_user_io | output | 1 | User I/O pins floated |

## Verification
The reset path into the instruction latch and the update path share the same falling edge. The bench therefore shifts the pin-driving code into the stage and then raises `tlr_st` and `update_ir` in the same cycle. It expects the identification code in the latch after the edge and `extest_mode` low, both while `tlr_st` is held and afterwards. The bench also checks that `extest_mode` falls at once when `tlr_st` rises while that code is already current. Random instruction codes from a seeded generator run alongside the directed table codes, and each decode is compared against a table kept in the bench.

// File: rtl/tir_pkg.sv
package tir_pkg;

   localparam int unsigned TIR_N_USER = 4;

   // default instruction codes (6-bit layout)
   localparam logic [5:0] TIR_C_EXTEST   = 6'h00;
   localparam logic [5:0] TIR_C_SAMPLE   = 6'h01;
   localparam logic [5:0] TIR_C_USERCODE = 6'h08;
   localparam logic [5:0] TIR_C_IDCODE   = 6'h09;
   localparam logic [5:0] TIR_C_HIZ      = 6'h0A;
   localparam logic [23:0] TIR_C_USERS   = {6'h23, 6'h22, 6'h03, 6'h02};

   typedef struct packed {
      logic                  bypass;
      logic                  idcode;
      logic                  usercode;
      logic                  bsr;
      logic [TIR_N_USER-1:0] user;
      logic                  extest;
      logic                  hiz;
   } tir_dec_t;

endpackage

// File: rtl/tir_shift.sv
module tir_shift #(
   parameter int unsigned    W   = 6,
   parameter logic [W-1:0]   PAT = '0
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         capture,
   input  logic         shift,
   input  logic         tdi,
   output logic [W-1:0] q
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      q <= PAT;
      else if (capture) q <= PAT;
      else if (shift)   q <= {tdi, q[W-1:1]};
   end
endmodule

// File: rtl/tir_latch.sv
module tir_latch #(
   parameter int unsigned  W       = 6,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         tlr,
   input  logic         update,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)     q <= RST_VAL;
      else if (tlr)    q <= RST_VAL;
      else if (update) q <= d;
   end
endmodule

// File: rtl/tir_decode.sv
module tir_decode
   import tir_pkg::*;
#(
   parameter int unsigned                   W        = 6,
   parameter bit                            HAS_ID   = 1'b1,
   parameter logic [W-1:0]                  K_EXTEST = '0,
   parameter logic [W-1:0]                  K_SAMPLE = '0,
   parameter logic [W-1:0]                  K_ID     = '0,
   parameter logic [W-1:0]                  K_UC     = '0,
   parameter logic [W-1:0]                  K_HIZ    = '0,
   parameter logic [TIR_N_USER*W-1:0]       K_USERS  = '0
) (
   input  logic [W-1:0] code,
   input  logic         tlr,
   output tir_dec_t     dec
);
   logic                  id_hit, uc_hit;
   logic [TIR_N_USER-1:0] user_hit;

   if (HAS_ID) begin : g_id
      assign id_hit = (code == K_ID);
      assign uc_hit = (code == K_UC);
   end else begin : g_noid
      assign id_hit = 1'b0;
      assign uc_hit = 1'b0;
   end

   for (genvar i = 0; i < TIR_N_USER; i++) begin : g_user
      assign user_hit[i] = (code == K_USERS[i*W +: W]);
   end

   always_comb begin
      dec = '0;
      if (code == K_EXTEST) begin
         dec.bsr    = 1'b1;
         dec.extest = 1'b1;
      end else if (code == K_SAMPLE) begin
         dec.bsr = 1'b1;
      end else if (id_hit) begin
         dec.idcode = 1'b1;
      end else if (uc_hit) begin
         dec.usercode = 1'b1;
      end else if (code == K_HIZ) begin
         dec.bypass = 1'b1;
         dec.hiz    = 1'b1;
      end else if (|user_hit) begin
         dec.user = user_hit;
      end else begin
         dec.bypass = 1'b1;
      end
      if (tlr) begin
         dec.extest = 1'b0;
         dec.hiz    = 1'b0;
      end
   end
endmodule

// File: rtl/tir_dreg.sv
module tir_dreg #(
   parameter int unsigned DW     = 32,
   parameter bit          HAS_ID = 1'b1,
   parameter logic [DW-1:0] ID_VAL = '0,
   parameter logic [DW-1:0] UC_VAL = '0
) (
   input  logic tck,
   input  logic trst_n,
   input  logic capture,
   input  logic shift,
   input  logic tdi,
   input  logic sel_byp,
   input  logic sel_id,
   input  logic sel_uc,
   output logic byp_so,
   output logic id_so
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_so <= 1'b0;
      else if (sel_byp && capture) byp_so <= 1'b0;
      else if (sel_byp && shift)   byp_so <= tdi;
   end

   if (HAS_ID) begin : g_idreg
      logic [DW-1:0] sr;
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)                          sr <= ID_VAL;
         else if ((sel_id || sel_uc) && capture) sr <= sel_id ? ID_VAL : UC_VAL;
         else if ((sel_id || sel_uc) && shift)   sr <= {tdi, sr[DW-1:1]};
      end
      assign id_so = sr[0];
   end else begin : g_noidreg
      assign id_so = 1'b0;
   end
endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
   import tir_pkg::*;
#(
   parameter int unsigned               IR_W     = 6,
   parameter int unsigned               DR_W     = 32,
   parameter bit                        HAS_ID   = 1'b1,
   parameter logic [IR_W-1:0]           CAP_PAT  = 6'b110001,
   parameter logic [DR_W-1:0]           ID_VAL   = 32'h1A3C5E97,
   parameter logic [DR_W-1:0]           UC_VAL   = 32'h5A5A0F0F,
   parameter logic [IR_W-1:0]           C_EXTEST = TIR_C_EXTEST,
   parameter logic [IR_W-1:0]           C_SAMPLE = TIR_C_SAMPLE,
   parameter logic [IR_W-1:0]           C_ID     = TIR_C_IDCODE,
   parameter logic [IR_W-1:0]           C_UC     = TIR_C_USERCODE,
   parameter logic [IR_W-1:0]           C_HIZ    = TIR_C_HIZ,
   parameter logic [TIR_N_USER*IR_W-1:0] C_USERS = TIR_C_USERS
) (
   input  logic                  tck,
   input  logic                  trst_n,
   input  logic                  tlr_st,
   input  logic                  capture_ir,
   input  logic                  shift_ir,
   input  logic                  update_ir,
   input  logic                  capture_dr,
   input  logic                  shift_dr,
   input  logic                  tdi,
   input  logic                  bsr_so,
   input  logic [TIR_N_USER-1:0] user_so,
   output logic                  tdo,
   output logic [IR_W-1:0]       ir_code,
   output logic                  sel_bypass,
   output logic                  sel_idcode,
   output logic                  sel_usercode,
   output logic                  sel_bsr,
   output logic [TIR_N_USER-1:0] sel_user,
   output logic                  extest_mode,
   output logic                  hiz_user_io
);
   localparam logic [IR_W-1:0] C_BYPASS = '1;
   localparam logic [IR_W-1:0] RST_CODE = HAS_ID ? C_ID : C_BYPASS;

   // elaboration-time parameter checks
   if (IR_W < 2) begin : g_chk_w
      $error("IR_W must be at least 2");
   end
   if (CAP_PAT[1:0] != 2'b01) begin : g_chk_pat
      $error("CAP_PAT low bits must be 01");
   end
   if (C_ID == C_UC || C_EXTEST == C_SAMPLE || C_HIZ == C_BYPASS) begin : g_chk_codes
      $error("instruction codes collide");
   end
   for (genvar i = 0; i < TIR_N_USER; i++) begin : g_chk_u
      for (genvar j = i + 1; j < TIR_N_USER; j++) begin : g_pair
         if (C_USERS[i*IR_W +: IR_W] == C_USERS[j*IR_W +: IR_W]) begin : g_dup
            $error("user codes collide");
         end
      end
   end

   logic [IR_W-1:0] ir_q;
   tir_dec_t        dec;
   logic            byp_so, id_so, dr_so;

   tir_shift #(.W(IR_W), .PAT(CAP_PAT)) u_shift (
      .tck(tck), .trst_n(trst_n), .capture(capture_ir), .shift(shift_ir),
      .tdi(tdi), .q(ir_q)
   );

   tir_latch #(.W(IR_W), .RST_VAL(RST_CODE)) u_latch (
      .tck(tck), .trst_n(trst_n), .tlr(tlr_st), .update(update_ir),
      .d(ir_q), .q(ir_code)
   );

   tir_decode #(
      .W(IR_W), .HAS_ID(HAS_ID), .K_EXTEST(C_EXTEST), .K_SAMPLE(C_SAMPLE),
      .K_ID(C_ID), .K_UC(C_UC), .K_HIZ(C_HIZ), .K_USERS(C_USERS)
   ) u_dec (
      .code(ir_code), .tlr(tlr_st), .dec(dec)
   );

   tir_dreg #(.DW(DR_W), .HAS_ID(HAS_ID), .ID_VAL(ID_VAL), .UC_VAL(UC_VAL)) u_dreg (
      .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
      .tdi(tdi), .sel_byp(dec.bypass), .sel_id(dec.idcode),
      .sel_uc(dec.usercode), .byp_so(byp_so), .id_so(id_so)
   );

   always_comb begin
      dr_so = byp_so;
      if (dec.idcode || dec.usercode) dr_so = id_so;
      if (dec.bsr)                    dr_so = bsr_so;
      for (int i = 0; i < TIR_N_USER; i++) begin
         if (dec.user[i]) dr_so = user_so[i];
      end
   end

   assign tdo          = shift_ir ? ir_q[0] : dr_so;
   assign sel_bypass   = dec.bypass;
   assign sel_idcode   = dec.idcode;
   assign sel_usercode = dec.usercode;
   assign sel_bsr      = dec.bsr;
   assign sel_user     = dec.user;
   assign extest_mode  = dec.extest;
   assign hiz_user_io  = dec.hiz;
endmodule

// File: rtl/tap_instr_unit_chk.sv
module tap_instr_unit_chk #(
   parameter int unsigned     IR_W     = 6,
   parameter logic [IR_W-1:0] CAP_PAT  = '0,
   parameter logic [IR_W-1:0] RST_CODE = '1
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tlr_st,
   input logic            capture_ir,
   input logic            shift_ir,
   input logic            update_ir,
   input logic            tdo,
   input logic [IR_W-1:0] ir_code,
   input logic [7:0]      sels,
   input logic            extest_mode,
   input logic            hiz_user_io
);
   AST_CAPTURE_LSB: assert property (@(posedge tck) disable iff (!trst_n)
      capture_ir |=> (!shift_ir || tdo == CAP_PAT[0])); // R1

   AST_CODE_HOLD: assert property (@(negedge tck) disable iff (!trst_n)
      (!update_ir && !tlr_st) |=> $stable(ir_code)); // R3

   AST_TLR_LOADS: assert property (@(negedge tck) disable iff (!trst_n)
      tlr_st |=> (ir_code == RST_CODE)); // R4

   AST_MODE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
      !(extest_mode && hiz_user_io)); // R9

   AST_TLR_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      tlr_st |-> (!extest_mode && !hiz_user_io)); // R10

   AST_ONE_SELECT: assert property (@(posedge tck) disable iff (!trst_n)
      $countones(sels) == 1); // R12
endmodule

bind tap_instr_unit tap_instr_unit_chk #(
   .IR_W(IR_W), .CAP_PAT(CAP_PAT), .RST_CODE(RST_CODE)
) u_chk (
   .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .capture_ir(capture_ir),
   .shift_ir(shift_ir), .update_ir(update_ir), .tdo(tdo), .ir_code(ir_code),
   .sels({sel_bypass, sel_idcode, sel_usercode, sel_bsr, sel_user}),
   .extest_mode(extest_mode), .hiz_user_io(hiz_user_io)
);

// File: tb/tap_instr_unit_tb.sv
`timescale 1ns/1ps
module tap_instr_unit_tb;
   localparam logic [5:0]  PAT = 6'b110001;
   localparam logic [31:0] IDV = 32'h1A3C5E97;
   localparam logic [31:0] UCV = 32'h5A5A0F0F;

   logic tck = 1'b0;
   logic trst_n, tlr_st, capture_ir, shift_ir, update_ir, capture_dr, shift_dr, tdi, bsr_so;
   logic [3:0] user_so, sel_user;
   logic tdo, sel_bypass, sel_idcode, sel_usercode, sel_bsr, extest_mode, hiz_user_io;
   logic [5:0] ir_code;
   logic [5:0] cur;
   int nchk = 0, nfail = 0;

   always #5 tck = ~tck;

   tap_instr_unit u_dut (
      .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .capture_ir(capture_ir),
      .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .tdi(tdi), .bsr_so(bsr_so), .user_so(user_so),
      .tdo(tdo), .ir_code(ir_code), .sel_bypass(sel_bypass), .sel_idcode(sel_idcode),
      .sel_usercode(sel_usercode), .sel_bsr(sel_bsr), .sel_user(sel_user),
      .extest_mode(extest_mode), .hiz_user_io(hiz_user_io)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge tck); #2;
   endtask

   // {bypass, idcode, usercode, bsr, user[3:0], extest, hiz}
   function automatic logic [9:0] exp_dec(logic [5:0] c);
      case (c)
         6'h00:   return 10'b0001_0000_10;
         6'h01:   return 10'b0001_0000_00;
         6'h02:   return 10'b0000_0001_00;
         6'h03:   return 10'b0000_0010_00;
         6'h22:   return 10'b0000_0100_00;
         6'h23:   return 10'b0000_1000_00;
         6'h08:   return 10'b0010_0000_00;
         6'h09:   return 10'b0100_0000_00;
         6'h0A:   return 10'b1000_0000_01;
         default: return 10'b1000_0000_00;
      endcase
   endfunction

   function automatic logic [9:0] dut_dec();
      return {sel_bypass, sel_idcode, sel_usercode, sel_bsr, sel_user, extest_mode, hiz_user_io};
   endfunction

   task automatic load_ir(logic [5:0] code, bit do_update);
      capture_ir = 1'b1; step(); capture_ir = 1'b0; shift_ir = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tdi = code[i]; #1;
         chk("R1 capture pattern bit", tdo, PAT[i]);
         step();
      end
      shift_ir = 1'b0;
      if (do_update) begin
         update_ir = 1'b1; #1;
         chk("R3 code before falling edge", ir_code, cur);
         @(negedge tck); #1;
         chk("R2 shifted code latched", ir_code, code);
         cur = code;
         step(); update_ir = 1'b0;
      end
   endtask

   task automatic check_path(logic [5:0] code);
      logic [9:0] e;
      logic prev, b;
      e = exp_dec(code);
      #1 chk("R5 decode", dut_dec(), e);
      chk("R9 mode outputs", {extest_mode, hiz_user_io}, e[1:0]);
      if (e[9]) begin
         capture_dr = 1'b1; step(); capture_dr = 1'b0; shift_dr = 1'b1;
         prev = 1'b0;
         for (int k = 0; k < 4; k++) begin
            b = 1'($urandom % 2); tdi = b; #1;
            chk("R6 bypass capture and delay", tdo, prev);
            prev = b; step();
         end
         shift_dr = 1'b0;
      end
      if (e[6]) begin
         shift_dr = 1'b1;
         for (int k = 0; k < 2; k++) begin
            bsr_so = k[0]; #1;
            chk("R11 boundary chain on tdo", tdo, k[0]);
         end
         shift_dr = 1'b0;
      end
      for (int u = 0; u < 4; u++) begin
         if (e[2+u]) begin
            user_so = 4'($urandom); shift_dr = 1'b1; #1;
            chk("R11 user register on tdo", tdo, user_so[u]);
            user_so = ~user_so; #1;
            chk("R11 user register on tdo", tdo, user_so[u]);
            shift_dr = 1'b0;
         end
      end
   endtask

   task automatic read_word(logic [31:0] w, string tag);
      logic [7:0] tail;
      tail = 8'($urandom);
      capture_dr = 1'b1; step(); capture_dr = 1'b0; shift_dr = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tdi = (i < 8) ? tail[i] : 1'b0; #1;
         chk(tag, tdo, (i < 32) ? w[i] : tail[i-32]);
         step();
      end
      shift_dr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [5:0] dir [12];
      void'($urandom(32'd20240611));
      trst_n = 1'b0; tlr_st = 1'b0; capture_ir = 1'b0; shift_ir = 1'b0; update_ir = 1'b0;
      capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0; bsr_so = 1'b0; user_so = '0;
      cur = 6'h09;
      step(); step(); #1;
      chk("R4 reset code", ir_code, 6'h09);
      chk("R12 reset select", dut_dec(), 10'b0100_0000_00);
      trst_n = 1'b1; step();

      // R7: identification word read out from reset
      read_word(IDV, "R7 IDCODE bit");

      // directed table codes
      dir = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h22, 6'h23, 6'h08, 6'h09, 6'h0A, 6'h07, 6'h3F, 6'h15};
      foreach (dir[i]) begin
         load_ir(dir[i], 1'b1);
         check_path(dir[i]);
      end

      load_ir(6'h08, 1'b1);
      read_word(UCV, "R7 USERCODE bit");

      // R8: bypass keeps its bit across an identification capture
      load_ir(6'h3F, 1'b1);
      shift_dr = 1'b1; tdi = 1'b1; step(); shift_dr = 1'b0;
      load_ir(6'h09, 1'b1);
      capture_dr = 1'b1; step(); capture_dr = 1'b0;
      load_ir(6'h3F, 1'b1);
      shift_dr = 1'b1; tdi = 1'b0; #1;
      chk("R8 bypass untouched by other capture", tdo, 1'b1);
      step(); shift_dr = 1'b0;

      // R8: identification register untouched by a bypass capture
      load_ir(6'h09, 1'b1);
      shift_dr = 1'b1;
      for (int i = 0; i < 32; i++) begin tdi = UCV[i]; step(); end
      shift_dr = 1'b0;
      load_ir(6'h3F, 1'b1);
      capture_dr = 1'b1; step(); capture_dr = 1'b0;
      load_ir(6'h09, 1'b1);
      shift_dr = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1 chk("R8 id register untouched by bypass capture", tdo, UCV[i]);
         step();
      end
      shift_dr = 1'b0;

      // R10: reset state drops pin-driving mode at once
      load_ir(6'h00, 1'b1);
      #1 chk("R9 extest active", extest_mode, 1'b1);
      tlr_st = 1'b1; #1;
      chk("R10 extest low during reset state", extest_mode, 1'b0);
      @(negedge tck); #1;
      chk("R4 reset state loads IDCODE", ir_code, 6'h09);
      cur = 6'h09;
      step(); tlr_st = 1'b0;

      // R10: reset state and update in the same cycle
      load_ir(6'h00, 1'b0);
      update_ir = 1'b1; tlr_st = 1'b1;
      @(negedge tck); #1;
      chk("R10 reset wins over update", ir_code, 6'h09);
      chk("R10 extest held low", extest_mode, 1'b0);
      step(); update_ir = 1'b0; tlr_st = 1'b0; #1;
      chk("R10 extest after collision", extest_mode, 1'b0);
      chk("R12 select after collision", dut_dec(), 10'b0100_0000_00);

      // HIZ keeps the test port working through bypass
      load_ir(6'h0A, 1'b1);
      check_path(6'h0A);

      // random codes
      for (int n = 0; n < 60; n++) begin
         logic [5:0] c;
         c = 6'($urandom);
         load_ir(c, 1'b1);
         #1 chk("R5 random decode", dut_dec(), exp_dec(c));
         chk("R12 single select", 64'($countones(dut_dec()) - ((c == 6'h00 || c == 6'h0A) ? 1 : 0)), 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule